// File: doc/BRIEF.md
# Binary64 Adder with Per-Operation Rounding Select

This block adds two IEEE 754 binary64 operands and returns the correctly rounded sum together with five exception flags: invalid, denormal-operand, overflow, underflow and inexact. It is one lane of a wider packed-add datapath. The result comes out of a single register stage, paced by a valid strobe.

The rounding direction is chosen for each operation. A static rounding field carried with the operation is used only when three conditions all hold: the operation runs at the widest vector length, the second operand comes from a register, and the operation's embedded-control bit is set. In every other case the mode comes from a global rounding-control value. When the second operand comes from memory, that same embedded bit has a different meaning (broadcast), so it does not select the rounding mode. The flags apply to one operation only. Accumulating them and delivering any trap is left to the surrounding logic.

Top module: `fpadd_top`

## Requirements
- R1: A result and its flags appear on `sum`/`flags` with `out_valid` high exactly one clock after `in_valid` is sampled high. `out_valid` is low in every cycle that does not follow an accepted operation.
- R2: While `in_valid` is low, `sum` and `flags` keep the values of the last accepted operation.
- R3: The static field `embed_rm` sets the rounding mode only when `vlen_sel` is 2'b10 (widest), `src_b_is_reg` is 1 and `embed_en` is 1. In every other combination, `global_rm` sets the mode.
- R4: Mode encoding: 2'b00 round to nearest, ties to even; 2'b01 toward minus infinity; 2'b10 toward plus infinity; 2'b11 toward zero. Finite sums are rounded correctly in the selected mode.
- R5: If either input is a NaN, the result is that NaN with the quiet bit (fraction MSB) forced to 1. Operand `op_a` takes priority over `op_b`. A signalling NaN on either input raises invalid.
- R6: Infinity plus infinity of the opposite sign returns 64'h7FF8000000000000 and raises invalid. Infinity plus any finite value, or plus infinity of the same sign, returns that infinity with no flag.
- R7: The denormal flag is raised whenever either input has a zero exponent field and a nonzero fraction.
- R8: An exact zero sum keeps the common sign when both operands have the same sign. When the operands have opposite signs, an exact zero sum is +0, except in toward-minus-infinity mode, where it is -0.
- R9: When the rounded exponent reaches the all-ones code, the overflow and inexact flags are raised. The result is infinity when the mode rounds away from zero for that sign (including nearest-even). Otherwise it is the largest finite value of that sign.
- R10: Flag bit positions: [0] invalid, [1] denormal, [2] overflow, [3] underflow, [4] inexact. The inexact flag is raised exactly when the rounded result differs from the exact sum.
- R11: Underflow is raised only for a result that is both subnormal and inexact. Sums of subnormals are returned exactly, with underflow clear.
- R12: During reset, `out_valid`, `sum` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| vlen_sel | input | 2 | Vector length of the operation; 2'b10 is the widest |
| src_b_is_reg | input | 1 | Second operand comes from a register (1) or from memory (0) |
| embed_en | input | 1 | Embedded-control bit of the operation |
| embed_rm | input | 2 | Static rounding field carried with the operation |
| global_rm | input | 2 | Global rounding-control value |
| out_valid | output | 1 | Result valid |
| sum | output | 64 | Rounded sum |
| flags | output | 5 | Exception flags for the result |

## Verification
The bench builds the adder with its default widths: an 11-bit exponent and a 52-bit fraction, which is exact binary64. With these widths the simulator's own double-precision arithmetic can serve as an independent reference for hundreds of nearest-even sums. Those sums include deep cancellation and alignment shifts beyond the guard bits. Hand-derived vectors cover the three directed modes, the four ways the mode is selected, NaN and infinity handling, the boundary between subnormal and normal, and overflow at the top of the exponent range.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_DOWN      = 2'b01,
    RM_UP        = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

  localparam int FLG_W   = 5;
  localparam int FLG_INV = 0;
  localparam int FLG_DEN = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 3;
  localparam int FLG_INX = 4;

  localparam logic [1:0] VLEN_WIDEST = 2'b10;

endpackage

// File: rtl/fpadd_rm_sel.sv
module fpadd_rm_sel
  import fpadd_pkg::*;
(
  input  logic [1:0] vlen_sel,
  input  logic       src_b_is_reg,
  input  logic       embed_en,
  input  logic [1:0] embed_rm,
  input  logic [1:0] global_rm,
  output rmode_e     rm
);

  logic use_static;

  // static field wins only for full-width, register-sourced operations
  always_comb begin
    use_static = (vlen_sel == VLEN_WIDEST) && src_b_is_reg && embed_en;
    rm         = use_static ? rmode_e'(embed_rm) : rmode_e'(global_rm);
  end

endmodule

// File: rtl/fpadd_classify.sv
module fpadd_classify #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic [EW+FW:0] v,
  output logic           sign,
  output logic [EW-1:0]  eff_exp,
  output logic [FW:0]    sig,
  output logic           is_inf,
  output logic           is_nan,
  output logic           is_snan,
  output logic           is_sub
);

  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;
  logic          exp_ones;
  logic          exp_zero;
  logic          frac_nz;

  always_comb begin
    sign     = v[EW+FW];
    exp_f    = v[EW+FW-1:FW];
    frac_f   = v[FW-1:0];
    exp_ones = &exp_f;
    exp_zero = ~|exp_f;
    frac_nz  = |frac_f;
    // subnormals share the scale of exponent code 1
    eff_exp  = exp_zero ? EW'(1) : exp_f;
    sig      = {~exp_zero, frac_f};
    is_inf   = exp_ones & ~frac_nz;
    is_nan   = exp_ones & frac_nz;
    is_snan  = is_nan & ~frac_f[FW-1];
    is_sub   = exp_zero & frac_nz;
  end

endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int W  = 56,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d,
  output logic [CW-1:0] cnt
);

  logic seen;

  always_comb begin
    cnt  = CW'(W);
    seen = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!seen && d[i]) begin
        cnt  = CW'(W - 1 - i);
        seen = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
#(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic [EW+FW:0]   a,
  input  logic [EW+FW:0]   b,
  input  rmode_e           rm,
  output logic [EW+FW:0]   res,
  output logic [FLG_W-1:0] flg
);

  localparam int DW  = EW + FW + 1;
  localparam int SW  = FW + 1;          // significand with hidden bit
  localparam int XW  = SW + 3;          // plus guard, round, sticky
  localparam int XEW = EW + 2;          // exponent with headroom
  localparam int LZW = $clog2(XW + 1);
  localparam logic [XEW-1:0] EMAX = XEW'((1 << EW) - 1);
  localparam logic [DW-1:0]  QNAN_DEF = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  // operand classification
  logic          a_s, b_s, a_inf, b_inf, a_nan, b_nan, a_snan, b_snan, a_sub, b_sub;
  logic [EW-1:0] a_e, b_e;
  logic [SW-1:0] a_sig, b_sig;

  fpadd_classify #(.EW(EW), .FW(FW)) u_cls_a (
    .v(a), .sign(a_s), .eff_exp(a_e), .sig(a_sig),
    .is_inf(a_inf), .is_nan(a_nan), .is_snan(a_snan), .is_sub(a_sub)
  );

  fpadd_classify #(.EW(EW), .FW(FW)) u_cls_b (
    .v(b), .sign(b_s), .eff_exp(b_e), .sig(b_sig),
    .is_inf(b_inf), .is_nan(b_nan), .is_snan(b_snan), .is_sub(b_sub)
  );

  // magnitude ordering and alignment
  logic          a_big;
  logic          big_s;
  logic [EW-1:0] big_e, sml_e, diff;
  logic [SW-1:0] big_sig, sml_sig;
  logic [XW-1:0] big_x, sml_x, sml_sh, sml_j;
  logic          sh_sticky;
  logic          eff_sub;
  logic [XW:0]   raw;

  always_comb begin
    a_big   = a[DW-2:0] >= b[DW-2:0];
    big_s   = a_big ? a_s   : b_s;
    big_e   = a_big ? a_e   : b_e;
    sml_e   = a_big ? b_e   : a_e;
    big_sig = a_big ? a_sig : b_sig;
    sml_sig = a_big ? b_sig : a_sig;
    diff    = big_e - sml_e;
    big_x   = {big_sig, 3'b000};
    sml_x   = {sml_sig, 3'b000};
    if (int'(diff) >= XW) begin
      sml_sh    = '0;
      sh_sticky = |sml_sig;
    end else begin
      sml_sh    = sml_x >> diff;
      sh_sticky = |(sml_x & ~({XW{1'b1}} << diff));
    end
    sml_j   = {sml_sh[XW-1:1], sml_sh[0] | sh_sticky};
    eff_sub = a_s ^ b_s;
    raw     = eff_sub ? ({1'b0, big_x} - {1'b0, sml_j})
                      : ({1'b0, big_x} + {1'b0, sml_j});
  end

  // normalization
  logic [LZW-1:0] lz;
  logic [XEW-1:0] lz_x, lim, sh, ne;
  logic [XW-1:0]  nrm;

  fpadd_lzc #(.W(XW)) u_lzc (
    .d   (raw[XW-1:0]),
    .cnt (lz)
  );

  always_comb begin
    lz_x = XEW'(lz);
    lim  = {2'b00, big_e} - XEW'(1);
    sh   = (lz_x < lim) ? lz_x : lim;
    if (raw[XW]) begin
      nrm = {raw[XW:2], raw[1] | raw[0]};
      ne  = {2'b00, big_e} + XEW'(1);
    end else begin
      nrm = raw[XW-1:0] << sh;
      ne  = {2'b00, big_e} - sh;
    end
  end

  // rounding
  logic [SW-1:0]  keep, mant;
  logic [2:0]     rb;
  logic           inexact, up, ovf, to_inf;
  logic [SW:0]    rnd;
  logic [XEW-1:0] re;
  logic [EW-1:0]  expf;

  always_comb begin
    keep    = nrm[XW-1:3];
    rb      = nrm[2:0];
    inexact = |rb;
    unique case (rm)
      RM_NEAR_EVEN: up = rb[2] & ((|rb[1:0]) | keep[0]);
      RM_DOWN:      up = big_s & inexact;
      RM_UP:        up = ~big_s & inexact;
      default:      up = 1'b0;
    endcase
    rnd = {1'b0, keep} + (SW+1)'(up);
    if (rnd[SW]) begin
      mant = rnd[SW:1];
      re   = ne + XEW'(1);
    end else begin
      mant = rnd[SW-1:0];
      re   = ne;
    end
    expf   = mant[SW-1] ? re[EW-1:0] : '0;
    ovf    = re >= EMAX;
    to_inf = (rm == RM_NEAR_EVEN) || (rm == RM_UP && !big_s) || (rm == RM_DOWN && big_s);
  end

  // result assembly, specials first
  always_comb begin
    res          = '0;
    flg          = '0;
    flg[FLG_DEN] = a_sub | b_sub;
    if (a_nan || b_nan) begin
      res          = a_nan ? a : b;
      res[FW-1]    = 1'b1;
      flg[FLG_INV] = a_snan | b_snan;
    end else if (a_inf && b_inf && eff_sub) begin
      res          = QNAN_DEF;
      flg[FLG_INV] = 1'b1;
    end else if (a_inf || b_inf) begin
      res = a_inf ? a : b;
    end else if (raw == '0) begin
      res[DW-1] = eff_sub ? (rm == RM_DOWN) : a_s;
    end else if (ovf) begin
      res          = to_inf ? {big_s, {EW{1'b1}}, {FW{1'b0}}}
                            : {big_s, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
      flg[FLG_OVF] = 1'b1;
      flg[FLG_INX] = 1'b1;
    end else begin
      res          = {big_s, expf, mant[FW-1:0]};
      flg[FLG_INX] = inexact;
      flg[FLG_UNF] = inexact & (expf == '0);
    end
  end

endmodule

// File: rtl/fpadd_top.sv
module fpadd_top
  import fpadd_pkg::*;
#(
  parameter int EW = 11,
  parameter int FW = 52,
  localparam int DW = EW + FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [1:0]    vlen_sel,
  input  logic          src_b_is_reg,
  input  logic          embed_en,
  input  logic [1:0]    embed_rm,
  input  logic [1:0]    global_rm,
  output logic          out_valid,
  output logic [DW-1:0] sum,
  output logic [4:0]    flags
);

  rmode_e          rm_sel;
  logic [DW-1:0]   core_res;
  logic [FLG_W-1:0] core_flg;

  fpadd_rm_sel u_rm_sel (
    .vlen_sel     (vlen_sel),
    .src_b_is_reg (src_b_is_reg),
    .embed_en     (embed_en),
    .embed_rm     (embed_rm),
    .global_rm    (global_rm),
    .rm           (rm_sel)
  );

  fpadd_core #(.EW(EW), .FW(FW)) u_core (
    .a   (op_a),
    .b   (op_b),
    .rm  (rm_sel),
    .res (core_res),
    .flg (core_flg)
  );

  logic            vld_d, vld_q;
  logic [DW-1:0]   sum_d, sum_q;
  logic [FLG_W-1:0] flg_d, flg_q;

  always_comb begin
    vld_d = in_valid;
    sum_d = sum_q;
    flg_d = flg_q;
    if (in_valid) begin
      sum_d = core_res;
      flg_d = core_flg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sum_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      sum_q <= sum_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid = vld_q;
  assign sum       = sum_q;
  assign flags     = flg_q;

endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk #(
  parameter int EW = 11,
  parameter int FW = 52,
  localparam int DW = EW + FW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] sum,
  input logic [4:0]    flags
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum) && $stable(flags)));

  // R9
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[2]) |-> flags[4]);

  // R11
  unf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[3]) |-> (flags[4] && sum[DW-2:FW] == '0));

  // R6
  invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[0]) |-> ((&sum[DW-2:FW]) && sum[FW-1]));

  // R5
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&sum[DW-2:FW]) && (|sum[FW-1:0])) |-> sum[FW-1]);

endmodule

bind fpadd_top fpadd_chk #(.EW(EW), .FW(FW)) u_fpadd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .sum       (sum),
  .flags     (flags)
);

// File: tb/tb_fpadd_top.sv
module tb_fpadd_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;
  localparam int NRAND = 300;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  vl;
    logic        rg;
    logic        ee;
    logic [1:0]  erm;
    logic [1:0]  grm;
    logic [63:0] exp_sum;
    logic [4:0]  exp_flg;
  } vec_t;

  // flags: [0] inv [1] den [2] ovf [3] unf [4] inx ; modes 0 RNE 1 down 2 up 3 zero
  localparam vec_t VECS [NVEC] = '{
    // R3 R4: global nearest, no embed
    '{64'h3FF0000000000000, 64'h3C30000000000000, 2'b10, 1'b1, 1'b0, 2'b10, 2'b00, 64'h3FF0000000000000, 5'h10},
    // R3: embed selected (widest, reg, bit set) -> up
    '{64'h3FF0000000000000, 64'h3C30000000000000, 2'b10, 1'b1, 1'b1, 2'b10, 2'b00, 64'h3FF0000000000001, 5'h10},
    // R3: narrower length -> global nearest
    '{64'h3FF0000000000000, 64'h3C30000000000000, 2'b01, 1'b1, 1'b1, 2'b10, 2'b00, 64'h3FF0000000000000, 5'h10},
    // R3: memory source -> bit is broadcast, global nearest
    '{64'h3FF0000000000000, 64'h3C30000000000000, 2'b10, 1'b0, 1'b1, 2'b10, 2'b00, 64'h3FF0000000000000, 5'h10},
    // R4: global up
    '{64'h3FF0000000000000, 64'h3C30000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b10, 64'h3FF0000000000001, 5'h10},
    // R4: negative, global down
    '{64'hBFF0000000000000, 64'hBC30000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b01, 64'hBFF0000000000001, 5'h10},
    // R4: negative, toward zero
    '{64'hBFF0000000000000, 64'hBC30000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b11, 64'hBFF0000000000000, 5'h10},
    // R8: x + -x nearest -> +0
    '{64'h3FF0000000000000, 64'hBFF0000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h0000000000000000, 5'h00},
    // R8: x + -x down -> -0
    '{64'h3FF0000000000000, 64'hBFF0000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b01, 64'h8000000000000000, 5'h00},
    // R8: -0 + -0 -> -0
    '{64'h8000000000000000, 64'h8000000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h8000000000000000, 5'h00},
    // R6: inf + -inf
    '{64'h7FF0000000000000, 64'hFFF0000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h7FF8000000000000, 5'h01},
    // R5: signalling NaN quieted, invalid
    '{64'h7FF0000000000001, 64'h3FF0000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h7FF8000000000001, 5'h01},
    // R5: quiet NaN on a
    '{64'h7FF8000000000005, 64'h3FF0000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h7FF8000000000005, 5'h00},
    // R5: quiet NaN on b
    '{64'h3FF0000000000000, 64'h7FF8000000000002, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h7FF8000000000002, 5'h00},
    // R5: both NaN, a wins
    '{64'h7FF8000000000007, 64'hFFF0000000000003, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h7FF8000000000007, 5'h01},
    // R6: inf + finite
    '{64'h3FF0000000000000, 64'hFFF0000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'hFFF0000000000000, 5'h00},
    // R9: overflow nearest -> inf
    '{64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h7FF0000000000000, 5'h14},
    // R9: overflow toward zero -> max
    '{64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 2'b10, 1'b1, 1'b0, 2'b00, 2'b11, 64'h7FEFFFFFFFFFFFFF, 5'h14},
    // R9: negative overflow up -> -max
    '{64'hFFEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 2'b10, 1'b1, 1'b0, 2'b00, 2'b10, 64'hFFEFFFFFFFFFFFFF, 5'h14},
    // R9: negative overflow down -> -inf
    '{64'hFFEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 2'b10, 1'b1, 1'b0, 2'b00, 2'b01, 64'hFFF0000000000000, 5'h14},
    // R11 R7: subnormal sum exact
    '{64'h0000000000000001, 64'h0000000000000001, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h0000000000000002, 5'h02},
    // R11 R7: subnormal sum carries into the normal range
    '{64'h000FFFFFFFFFFFFF, 64'h0000000000000001, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h0010000000000000, 5'h02},
    // R4 R10: tie to even rounds up on odd lsb
    '{64'h3FF0000000000001, 64'h3CA0000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h3FF0000000000002, 5'h10},
    // R7 R10: normal + subnormal
    '{64'h3FF0000000000000, 64'h0000000000000001, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 64'h3FF0000000000000, 5'h12}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_a, op_b;
  logic [1:0]  vlen_sel;
  logic        src_b_is_reg;
  logic        embed_en;
  logic [1:0]  embed_rm;
  logic [1:0]  global_rm;
  logic        out_valid;
  logic [63:0] sum;
  logic [4:0]  flags;

  int  n_checks;
  int  n_fail;
  bit  done;

  fpadd_top dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_a         (op_a),
    .op_b         (op_b),
    .vlen_sel     (vlen_sel),
    .src_b_is_reg (src_b_is_reg),
    .embed_en     (embed_en),
    .embed_rm     (embed_rm),
    .global_rm    (global_rm),
    .out_valid    (out_valid),
    .sum          (sum),
    .flags        (flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [1:0] vl,
                       input logic rg, input logic ee, input logic [1:0] erm, input logic [1:0] grm);
    @(negedge clk);
    op_a = a; op_b = b; vlen_sel = vl; src_b_is_reg = rg;
    embed_en = ee; embed_rm = erm; global_rm = grm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0;
    op_a = '0; op_b = '0; vlen_sel = '0; src_b_is_reg = 1'b0;
    embed_en = 1'b0; embed_rm = '0; global_rm = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 out_valid", 64'(out_valid), 64'd0);
    check("R12 sum", sum, 64'd0);
    check("R12 flags", 64'(flags), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle out_valid", 64'(out_valid), 64'd0);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].a, VECS[i].b, VECS[i].vl, VECS[i].rg, VECS[i].ee, VECS[i].erm, VECS[i].grm);
      check("R1 out_valid", 64'(out_valid), 64'd1);
      check($sformatf("R4 sum vec%0d", i), sum, VECS[i].exp_sum);
      check($sformatf("R10 flags vec%0d", i), 64'(flags), 64'(VECS[i].exp_flg));
    end

    // R2: inputs change without in_valid, output holds
    issue(64'h4000000000000000, 64'h4008000000000000, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00);
    check("R4 2+3", sum, 64'h4014000000000000);
    @(negedge clk);
    op_a = 64'h7FF0000000000001; op_b = 64'h3FF0000000000000;
    @(negedge clk);
    @(negedge clk);
    check("R2 hold sum", sum, 64'h4014000000000000);
    check("R2 hold flags", 64'(flags), 64'd0);
    check("R1 no valid", 64'(out_valid), 64'd0);

    // R4: nearest-even sums against the host's double arithmetic
    for (int k = 0; k < NRAND; k++) begin
      logic [63:0] ra, rb, rexp;
      int ea, eb;
      ea = 1000 + int'($urandom % 48);
      eb = ea - int'($urandom % 60);
      ra = {1'($urandom), 11'(ea), $urandom, 20'($urandom)};
      rb = {1'($urandom), 11'(eb), $urandom, 20'($urandom)};
      if (k % 4 == 0) rb = {~ra[63], ra[62:4], 4'($urandom)};
      rexp = $realtobits($bitstoreal(ra) + $bitstoreal(rb));
      issue(ra, rb, 2'b00, 1'b1, 1'b0, 2'b00, 2'b00);
      check("R4 nearest random", sum, rexp);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule